// File: doc/BRIEF.md
# Single-Precision Compare, Select and Sign Unit

This unit performs the non-arithmetic single-precision operations of a RISC-V core with floating-point support. It takes two 32-bit IEEE-754 operands, a 64-bit integer operand and a 4-bit operation code. It registers a 32-bit float result, a 64-bit integer result and an invalid-operation flag, one clock after the operands are presented.

Three sign-injection variants, minimum, maximum and three ordered compares are served by one sign-magnitude comparator and one pair of operand classifiers. The unit follows the RISC-V rules for NaN operands and signed zeros. Two raw bit moves copy values between the integer and float register files without any conversion. Arithmetic and format conversion are handled elsewhere.

Top module: `fcs_unit`

## Requirements
- R1: Operation codes are 0 sign-inject, 1 negated sign-inject, 2 xor sign-inject, 3 min, 4 max, 5 equal, 6 less-than, 7 less-or-equal, 8 float-to-integer move, 9 integer-to-float move. All outputs are registered: inputs sampled at one rising edge appear after that edge. A synchronous active-high reset clears every output to zero.
- R2: Sign injection returns bits 30:0 of operand A with sign bit 31 equal to B's sign (code 0), the inverse of B's sign (code 1) or the XOR of both signs (code 2).
- R3: Min returns the smaller and max the larger non-NaN operand, in sign-magnitude order: among negative values a larger magnitude is smaller.
- R4: +0 (0x00000000) and -0 (0x80000000) compare equal, but min returns -0 and max returns +0.
- R5: When one min/max operand is a NaN (exponent all ones, mantissa nonzero), the other operand is returned; when both are NaN the result is 0x7FC00000.
- R6: Compares return 1 or 0 in bit 0 of the integer result, bits 63:1 zero; any compare with a NaN operand returns 0.
- R7: The invalid flag is set by less-than and less-or-equal when any operand is NaN, and by equal, min and max only when an operand is a signaling NaN (NaN with mantissa bit 22 clear). No other operation sets it.
- R8: The float-to-integer move returns operand A in bits 31:0 with bit 31 copied into bits 63:32; the integer-to-float move returns bits 31:0 of the integer operand as the float result.
- R9: The result not produced by an operation (integer result for float-producing codes, float result for integer-producing codes) is zero; codes 10 to 15 give all-zero outputs and no invalid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Float operand A |
| b_i | input | 32 | Float operand B |
| xin_i | input | 64 | Integer operand for the integer-to-float move |
| fres_o | output | 32 | Registered float result |
| ires_o | output | 64 | Registered integer result |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
Assertions watch every cycle that compare results stay zero-extended, that a NaN compare never reads true, that two NaNs into min or max always yield the canonical NaN, that sign injection never alters A's exponent and mantissa, that the comparator never reports less-than and equal together, and that the invalid flag appears only after compare or min/max codes. Which operand min and max select, the handling of signed zeros, the negative-magnitude ordering, the exact invalid cases and the move bit patterns are only shown by the bench's directed scenarios with values worked out by hand.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [3:0] {
    OP_SINJ   = 4'd0,
    OP_SINJN  = 4'd1,
    OP_SINJX  = 4'd2,
    OP_MIN    = 4'd3,
    OP_MAX    = 4'd4,
    OP_EQ     = 4'd5,
    OP_LT     = 4'd6,
    OP_LE     = 4'd7,
    OP_F2I    = 4'd8,
    OP_I2F    = 4'd9,
    OP_IDLE   = 4'd15
  } fcs_op_e;

endpackage

// File: rtl/fcs_classify.sv
module fcs_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  output logic                 nan_o,
  output logic                 snan_o
);
  logic exp_max;
  logic man_nz;

  always_comb begin
    exp_max = &val_i[MAN_W +: EXP_W];
    man_nz  = |val_i[MAN_W-1:0];
    nan_o   = exp_max && man_nz;
    snan_o  = nan_o && !val_i[MAN_W-1];
  end
endmodule

// File: rtl/fcs_order.sv
module fcs_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_o,
  output logic         eq_o
);
  logic         sa, sb;
  logic [W-2:0] ma, mb;

  always_comb begin
    sa = a_i[W-1];
    sb = b_i[W-1];
    ma = a_i[W-2:0];
    mb = b_i[W-2:0];
    if (ma == '0 && mb == '0) begin
      lt_o = 1'b0;
      eq_o = 1'b1;
    end else if (sa != sb) begin
      lt_o = sa;
      eq_o = 1'b0;
    end else begin
      eq_o = (ma == mb);
      lt_o = sa ? (ma > mb) : (ma < mb);
    end
  end
endmodule

// File: rtl/fcs_signinj.sv
module fcs_signinj #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] y_o
);
  logic s;

  always_comb begin
    case (mode_i)
      2'd1:    s = !b_i[W-1];
      2'd2:    s = a_i[W-1] ^ b_i[W-1];
      default: s = b_i[W-1];
    endcase
    y_o = {s, a_i[W-2:0]};
  end
endmodule

// File: rtl/fcs_unit.sv
module fcs_unit #(
  parameter int XLEN  = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FLEN = 1 + EXP_W + MAN_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op_i,
  input  logic [FLEN-1:0] a_i,
  input  logic [FLEN-1:0] b_i,
  input  logic [XLEN-1:0] xin_i,
  output logic [FLEN-1:0] fres_o,
  output logic [XLEN-1:0] ires_o,
  output logic            invalid_o
);
  import fcs_pkg::*;

  localparam logic [FLEN-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  fcs_op_e op;
  fcs_op_e op_q;
  assign op = fcs_op_e'(op_i);

  logic [FLEN-1:0] opnd [2];
  logic [1:0]      is_nan;
  logic [1:0]      is_snan;
  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    fcs_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val_i (opnd[k]),
      .nan_o (is_nan[k]),
      .snan_o(is_snan[k])
    );
  end

  logic ord_lt, ord_eq;
  fcs_order #(.W(FLEN)) u_ord (
    .a_i (a_i),
    .b_i (b_i),
    .lt_o(ord_lt),
    .eq_o(ord_eq)
  );

  logic [FLEN-1:0] sinj_y;
  fcs_signinj #(.W(FLEN)) u_sinj (
    .a_i   (a_i),
    .b_i   (b_i),
    .mode_i(op_i[1:0]),
    .y_o   (sinj_y)
  );

  logic [FLEN-1:0] f_d;
  logic [XLEN-1:0] i_d;
  logic            inv_d;
  logic            any_nan, any_snan, pick_a;

  always_comb begin
    f_d      = '0;
    i_d      = '0;
    inv_d    = 1'b0;
    any_nan  = |is_nan;
    any_snan = |is_snan;
    pick_a   = 1'b0;
    case (op)
      OP_SINJ, OP_SINJN, OP_SINJX: f_d = sinj_y;
      OP_MIN, OP_MAX: begin
        inv_d = any_snan;
        if (op == OP_MIN) pick_a = ord_lt || (ord_eq && a_i[FLEN-1]);
        else              pick_a = (!ord_lt && !ord_eq) || (ord_eq && !a_i[FLEN-1]);
        if (&is_nan)        f_d = CANON_NAN;
        else if (is_nan[0]) f_d = b_i;
        else if (is_nan[1]) f_d = a_i;
        else                f_d = pick_a ? a_i : b_i;
      end
      OP_EQ: begin
        inv_d  = any_snan;
        i_d[0] = !any_nan && ord_eq;
      end
      OP_LT: begin
        inv_d  = any_nan;
        i_d[0] = !any_nan && ord_lt;
      end
      OP_LE: begin
        inv_d  = any_nan;
        i_d[0] = !any_nan && (ord_lt || ord_eq);
      end
      OP_F2I: i_d = {{(XLEN-FLEN){a_i[FLEN-1]}}, a_i};
      OP_I2F: f_d = xin_i[FLEN-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fres_o    <= '0;
      ires_o    <= '0;
      invalid_o <= 1'b0;
      op_q      <= OP_IDLE;
    end else begin
      fres_o    <= f_d;
      ires_o    <= i_d;
      invalid_o <= inv_d;
      op_q      <= op;
    end
  end

  // R3: comparator never reports both orderings
  a_r3_order_excl: assert property (@(posedge clk) disable iff (rst)
    !(ord_lt && ord_eq));

  // R2: sign injection keeps A's exponent and mantissa
  a_r2_sinj_body: assert property (@(posedge clk) disable iff (rst)
    (op_q inside {OP_SINJ, OP_SINJN, OP_SINJX}) |-> fres_o[FLEN-2:0] == $past(a_i[FLEN-2:0]));

  // R5: two NaNs into min/max give the canonical NaN
  a_r5_both_nan_canon: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_MIN || op == OP_MAX) && is_nan[0] && is_nan[1]) |=> fres_o == CANON_NAN);

  // R6: compare result is zero-extended
  a_r6_cmp_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (op_q inside {OP_EQ, OP_LT, OP_LE}) |-> ires_o[XLEN-1:1] == '0);

  // R6: a NaN operand never makes a compare true
  a_r6_nan_cmp_false: assert property (@(posedge clk) disable iff (rst)
    ((op inside {OP_EQ, OP_LT, OP_LE}) && (is_nan != 2'b00)) |=> ires_o == '0);

  // R7: invalid only follows compare or min/max codes
  a_r7_inv_scope: assert property (@(posedge clk) disable iff (rst)
    invalid_o |-> (op_q inside {OP_MIN, OP_MAX, OP_EQ, OP_LT, OP_LE}));

endmodule

// File: tb/tb_fcs_unit.sv
`timescale 1ns/1ps
module tb_fcs_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op_i;
  logic [31:0] a_i, b_i;
  logic [63:0] xin_i;
  logic [31:0] fres_o;
  logic [63:0] ires_o;
  logic        invalid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] P_ONE = 32'h3F800000, N_ONE = 32'hBF800000;
  localparam logic [31:0] P_TWO = 32'h40000000, N_TWO = 32'hC0000000;
  localparam logic [31:0] P_ZERO = 32'h00000000, N_ZERO = 32'h80000000;
  localparam logic [31:0] QNAN = 32'h7FC00000, SNAN = 32'h7F800001, P_INF = 32'h7F800000;

  always #4 clk = ~clk;

  fcs_unit dut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .xin_i(xin_i),
    .fres_o(fres_o), .ires_o(ires_o), .invalid_o(invalid_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] x);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; xin_i = x;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fcase(input string req, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] ef, input logic ei);
    apply(op, a, b, 64'h0);
    chk(req, {32'h0, fres_o}, {32'h0, ef});
    chk({req, " ires zero R9"}, ires_o, 64'h0);
    chk({req, " invalid"}, {63'h0, invalid_o}, {63'h0, ei});
  endtask

  task automatic ccase(input string req, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic ebit, input logic ei);
    apply(op, a, b, 64'h0);
    chk(req, ires_o, {63'h0, ebit});
    chk({req, " fres zero R9"}, {32'h0, fres_o}, 64'h0);
    chk({req, " invalid"}, {63'h0, invalid_o}, {63'h0, ei});
  endtask

  task automatic t_reset();
    rst = 1'b1; op_i = 4'd8; a_i = N_ONE; b_i = 0; xin_i = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset fres", {32'h0, fres_o}, 64'h0);
    chk("R1 reset ires", ires_o, 64'h0);
    chk("R1 reset invalid", {63'h0, invalid_o}, 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_sign();
    fcase("R2 sinj", 4'd0, P_ONE, N_TWO, N_ONE, 1'b0);
    fcase("R2 sinjn", 4'd1, P_ONE, N_TWO, P_ONE, 1'b0);
    fcase("R2 sinjx", 4'd2, N_ONE, N_TWO, P_ONE, 1'b0);
    fcase("R2 sinjx pos", 4'd2, N_ONE, P_TWO, N_ONE, 1'b0);
  endtask

  task automatic t_minmax();
    fcase("R3 min mixed", 4'd3, N_TWO, P_ONE, N_TWO, 1'b0);
    fcase("R3 max mixed", 4'd4, N_TWO, P_ONE, P_ONE, 1'b0);
    fcase("R3 min neg mag", 4'd3, N_ONE, N_TWO, N_TWO, 1'b0);
    fcase("R3 max neg mag", 4'd4, N_ONE, N_TWO, N_ONE, 1'b0);
    fcase("R3 max inf", 4'd4, P_INF, P_TWO, P_INF, 1'b0);
  endtask

  task automatic t_zeros();
    fcase("R4 min +0,-0", 4'd3, P_ZERO, N_ZERO, N_ZERO, 1'b0);
    fcase("R4 max -0,+0", 4'd4, N_ZERO, P_ZERO, P_ZERO, 1'b0);
    ccase("R4 eq +0,-0", 4'd5, P_ZERO, N_ZERO, 1'b1, 1'b0);
    ccase("R4 lt -0,+0", 4'd6, N_ZERO, P_ZERO, 1'b0, 1'b0);
  endtask

  task automatic t_nan_minmax();
    fcase("R5 min qnan,2", 4'd3, QNAN, P_TWO, P_TWO, 1'b0);
    fcase("R5 max 1,snan", 4'd4, P_ONE, SNAN, P_ONE, 1'b1);
    fcase("R5 min both nan", 4'd3, QNAN, SNAN | 32'h80000000, QNAN, 1'b1);
  endtask

  task automatic t_compare();
    ccase("R6 lt neg", 4'd6, N_TWO, N_ONE, 1'b1, 1'b0);
    ccase("R6 le equal", 4'd7, P_ONE, P_ONE, 1'b1, 1'b0);
    ccase("R6 lt equal", 4'd6, P_ONE, P_ONE, 1'b0, 1'b0);
    ccase("R6 le inf", 4'd7, P_ONE, P_INF, 1'b1, 1'b0);
    ccase("R6 eq diff", 4'd5, P_ONE, P_TWO, 1'b0, 1'b0);
  endtask

  task automatic t_nan_cmp();
    ccase("R7 eq qnan", 4'd5, QNAN, P_ONE, 1'b0, 1'b0);
    ccase("R7 eq snan", 4'd5, SNAN, P_ONE, 1'b0, 1'b1);
    ccase("R7 lt qnan", 4'd6, QNAN, P_ONE, 1'b0, 1'b1);
    ccase("R7 le qnan same", 4'd7, QNAN, QNAN, 1'b0, 1'b1);
  endtask

  task automatic t_moves();
    apply(4'd8, N_ONE, P_TWO, 64'h0);
    chk("R8 f2i neg", ires_o, 64'hFFFFFFFF_BF800000);
    chk("R8 f2i fres zero R9", {32'h0, fres_o}, 64'h0);
    apply(4'd8, P_ONE, N_TWO, 64'h0);
    chk("R8 f2i pos", ires_o, 64'h00000000_3F800000);
    apply(4'd9, P_ONE, P_ONE, 64'h12345678_9ABCDEF0);
    chk("R8 i2f", {32'h0, fres_o}, 64'h9ABCDEF0);
    chk("R8 i2f ires zero R9", ires_o, 64'h0);
  endtask

  task automatic t_unused();
    for (int c = 10; c < 16; c++) begin
      apply(4'(c), SNAN, QNAN, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R9 unused fres", {32'h0, fres_o}, 64'h0);
      chk("R9 unused ires", ires_o, 64'h0);
      chk("R9 unused invalid", {63'h0, invalid_o}, 64'h0);
    end
  endtask

  task automatic t_latency();
    // R1: result follows the edge that samples the inputs
    @(negedge clk);
    op_i = 4'd0; a_i = P_TWO; b_i = N_ONE;
    @(posedge clk);
    #1;
    chk("R1 latency", {32'h0, fres_o}, {32'h0, N_TWO});
  endtask

  initial begin
    t_reset();
    t_sign();
    t_minmax();
    t_zeros();
    t_nan_minmax();
    t_compare();
    t_nan_cmp();
    t_moves();
    t_unused();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule